// File: doc/BRIEF.md
# Paged Data Address Translator

This block turns a 16-bit logical data address into a 24-bit physical address. The two top bits of the logical address pick one of four page registers. The 14 low bits are kept as the offset within that page. The physical address is the selected 10-bit page number followed by that 14-bit offset. For example, logical 0x9555 with page register 2 set to 0x001 gives physical 0x005555. After reset the four page registers hold 0, 1, 2 and 3, so physical equals logical.

An extend command can open a short override window that covers a fixed number of the instructions that follow it.

- In page override, every covered data access uses the page number supplied by the command, whatever the selector bits say.
- In segment override, the whole 16-bit logical address is the low part of the physical address, and the supplied segment value forms the top 8 bits.

A single counter, loaded with the command's length, is decremented by every retired instruction. A new command issued inside an open window reloads the counter, which chains windows together. A class-B trap flag closes the window at once and blocks new commands for as long as it is held. Stack and indirect-pointer fetches, signalled with `data_acc` low, always use normal page translation.

Top module: `page_xlate`

## Requirements
- R1: After reset, `phys_valid` is 0, and a normal access returns the logical address zero-extended to 24 bits (page registers reset to 0, 1, 2 and 3).
- R2: A normal access returns `{page[log_addr[15:14]], log_addr[13:0]}` on `phys_addr`, with `phys_valid` high, in the clock cycle after `acc_valid`.
- R3: A page register write (`pg_wr_en`, `pg_wr_sel`, `pg_wr_val`) applies from the next cycle on. An access in the same cycle as the write uses the old value.
- R4: Command kinds 01 and 11 select page override. A covered data access returns `{cmd_val, log_addr[13:0]}`.
- R5: Command kinds 00 and 10 select segment override. A covered data access returns `{cmd_val[7:0], log_addr[15:0]}`.
- R6: The `cmd_len` field holds the window length minus 1, so lengths run from 1 to 4. The retire pulse in the command's own cycle is not counted. Each later `instr_done` pulse counts one covered instruction. Accesses up to and including the cycle of the last covered retire pulse are overridden; accesses after that are translated normally.
- R7: A command accepted while a window is open replaces the mode and value and reloads the counter with the new length.
- R8: While `trap_b` is high, no access is overridden, and any open window is closed from the next cycle on.
- R9: A command issued while `trap_b` is high is ignored. After `trap_b` falls, accesses are translated normally.
- R10: An access with `data_acc` low is never overridden, even inside an open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| log_addr | input | 16 | Logical address |
| data_acc | input | 1 | 1 = ordinary data access, 0 = stack or indirect-pointer fetch |
| pg_wr_en | input | 1 | Page register write strobe |
| pg_wr_sel | input | 2 | Page register index |
| pg_wr_val | input | 10 | Page register write value |
| cmd_valid | input | 1 | Extend command strobe |
| cmd_kind | input | 2 | 00 segment, 01 page, 10 segment with register, 11 page with register |
| cmd_val | input | 10 | Page number, or segment number in bits 7:0 |
| cmd_len | input | 2 | Window length minus 1 |
| instr_done | input | 1 | Instruction-retired pulse |
| trap_b | input | 1 | Any class-B trap flag set |
| phys_valid | output | 1 | Physical address valid |
| phys_addr | output | 24 | Physical address |

## Verification
The hardest cases to reach are where the window boundary coincides with other events. These include a reload arriving while retire pulses are still counting down, and a trap that lands inside an open window while an access is on the same cycle. The stimulus chains a length-2 window into a length-4 one, probing after every retire pulse, and raises the trap together with an access in the middle of a window. A reference model in the bench follows every cycle of these sequences and predicts the address expected for each access.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    typedef enum logic [1:0] {
        XK_SEG    = 2'b00,
        XK_PAGE   = 2'b01,
        XK_SEG_R  = 2'b10,
        XK_PAGE_R = 2'b11
    } xkind_e;
endpackage

// File: rtl/xlt_page_file.sv
module xlt_page_file #(
    parameter int NPG   = 4,
    parameter int PG_W  = 10,
    localparam int SEL_W = $clog2(NPG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [PG_W-1:0]  wr_val,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [PG_W-1:0]  rd_val
);
    logic [NPG-1:0][PG_W-1:0] pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (wr_en) pg_d[wr_sel] = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPG; i++) pg_q[i] <= PG_W'(i);
        end else begin
            pg_q <= pg_d;
        end
    end

    assign rd_val = pg_q[rd_sel];

    AST_PG_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pg_q[$past(wr_sel)] == $past(wr_val)); // R3
endmodule

// File: rtl/xlt_ext_window.sv
module xlt_ext_window
    import xlt_pkg::*;
#(
    parameter int PG_W    = 10,
    parameter int MAX_LEN = 4,
    localparam int LEN_W  = $clog2(MAX_LEN),
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic [PG_W-1:0]  cmd_val,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             retire,
    input  logic             trap,
    output logic             ovr_on,
    output logic             ovr_seg,
    output logic [PG_W-1:0]  ovr_val
);
    typedef struct packed {
        logic             active;
        logic             seg;
        logic [CNT_W-1:0] cnt;
        logic [PG_W-1:0]  val;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (trap) begin
            w_d.active = 1'b0;
            w_d.cnt    = '0;
        end else if (cmd_valid) begin
            w_d.active = 1'b1;
            w_d.seg    = (cmd_kind == XK_SEG) || (cmd_kind == XK_SEG_R);
            w_d.val    = cmd_val;
            w_d.cnt    = CNT_W'(cmd_len) + CNT_W'(1);
        end else if (retire && w_q.active) begin
            w_d.cnt = w_q.cnt - CNT_W'(1);
            if (w_q.cnt == CNT_W'(1)) w_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign ovr_on  = w_q.active && !trap;
    assign ovr_seg = w_q.seg;
    assign ovr_val = w_q.val;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.cnt <= CNT_W'(MAX_LEN)); // R6
    AST_ACTIVE_HAS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.active |-> w_q.cnt != '0); // R6
    AST_LAST_RETIRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.active && w_q.cnt == CNT_W'(1) && retire && !cmd_valid && !trap) |=> !w_q.active); // R6
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !trap) |=> (w_q.active && w_q.cnt == CNT_W'($past(cmd_len)) + CNT_W'(1))); // R7
    AST_TRAP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !w_q.active); // R8
    AST_TRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !ovr_on); // R9
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
    parameter int LA_W    = 16,
    parameter int PA_W    = 24,
    parameter int NPG     = 4,
    parameter int MAX_LEN = 4,
    localparam int SEL_W  = $clog2(NPG),
    localparam int OFF_W  = LA_W - SEL_W,
    localparam int PG_W   = PA_W - OFF_W,
    localparam int SEG_W  = PA_W - LA_W,
    localparam int LEN_W  = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [LA_W-1:0]  log_addr,
    input  logic             data_acc,
    input  logic             pg_wr_en,
    input  logic [SEL_W-1:0] pg_wr_sel,
    input  logic [PG_W-1:0]  pg_wr_val,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic [PG_W-1:0]  cmd_val,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             instr_done,
    input  logic             trap_b,
    output logic             phys_valid,
    output logic [PA_W-1:0]  phys_addr
);
    typedef struct packed {
        logic            vld;
        logic [PA_W-1:0] addr;
    } out_t;

    logic [PG_W-1:0] pg_sel_val;
    logic            ovr_on, ovr_seg;
    logic [PG_W-1:0] ovr_val;
    out_t            o_d, o_q;

    xlt_page_file #(.NPG(NPG), .PG_W(PG_W)) u_pages (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pg_wr_en),
        .wr_sel (pg_wr_sel),
        .wr_val (pg_wr_val),
        .rd_sel (log_addr[LA_W-1 -: SEL_W]),
        .rd_val (pg_sel_val)
    );

    xlt_ext_window #(.PG_W(PG_W), .MAX_LEN(MAX_LEN)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_val   (cmd_val),
        .cmd_len   (cmd_len),
        .retire    (instr_done),
        .trap      (trap_b),
        .ovr_on    (ovr_on),
        .ovr_seg   (ovr_seg),
        .ovr_val   (ovr_val)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = acc_valid;
        if (acc_valid) begin
            if (ovr_on && data_acc) begin
                if (ovr_seg) o_d.addr = {ovr_val[SEG_W-1:0], log_addr};
                else         o_d.addr = {ovr_val, log_addr[OFF_W-1:0]};
            end else begin
                o_d.addr = {pg_sel_val, log_addr[OFF_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign phys_valid = o_q.vld;
    assign phys_addr  = o_q.addr;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> phys_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !phys_valid); // R2
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> phys_addr[OFF_W-1:0] == $past(log_addr[OFF_W-1:0])); // R2
    AST_STACK_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !data_acc) |=> phys_addr[PA_W-1 -: PG_W] == $past(pg_sel_val)); // R10
endmodule

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, data_acc = 1'b1;
    logic [15:0] log_addr = '0;
    logic        pg_wr_en = 1'b0;
    logic [1:0]  pg_wr_sel = '0;
    logic [9:0]  pg_wr_val = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic [9:0]  cmd_val = '0;
    logic [1:0]  cmd_len = '0;
    logic        instr_done = 1'b0, trap_b = 1'b0;
    logic        phys_valid;
    logic [23:0] phys_addr;

    int n_chk = 0, n_fail = 0;
    logic [23:0] q_exp[$];
    string       q_tag[$];

    // reference model
    logic [9:0] m_pg [4];
    logic       m_act, m_seg;
    int         m_cnt;
    logic [9:0] m_val;

    always #4 clk = ~clk;

    page_xlate u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .log_addr(log_addr),
        .data_acc(data_acc), .pg_wr_en(pg_wr_en), .pg_wr_sel(pg_wr_sel),
        .pg_wr_val(pg_wr_val), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_val(cmd_val), .cmd_len(cmd_len), .instr_done(instr_done),
        .trap_b(trap_b), .phys_valid(phys_valid), .phys_addr(phys_addr)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: compare each produced address against the scoreboard
    always @(negedge clk) begin
        if (rst_n && phys_valid) begin
            n_chk++;
            if (q_exp.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected phys_valid, addr=%06h expected no output", phys_addr);
            end else begin
                logic [23:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (phys_addr !== e) begin
                    n_fail++;
                    $display("FAIL %s: phys_addr=%06h expected %06h", t, phys_addr, e);
                end
            end
        end
    end

    // one clock cycle with the inputs already set; predicts and updates the model
    task automatic tick(input string tag);
        if (acc_valid) begin
            logic [23:0] e;
            if (m_act && !trap_b && data_acc)
                e = m_seg ? {m_val[7:0], log_addr} : {m_val, log_addr[13:0]};
            else
                e = {m_pg[log_addr[15:14]], log_addr[13:0]};
            q_exp.push_back(e);
            q_tag.push_back(tag);
        end
        @(posedge clk);
        if (trap_b) begin
            m_act = 1'b0; m_cnt = 0;
        end else if (cmd_valid) begin
            m_act = 1'b1;
            m_seg = (cmd_kind == 2'b00) || (cmd_kind == 2'b10);
            m_val = cmd_val;
            m_cnt = int'(cmd_len) + 1;
        end else if (instr_done && m_act) begin
            m_cnt--;
            if (m_cnt == 0) m_act = 1'b0;
        end
        if (pg_wr_en) m_pg[pg_wr_sel] = pg_wr_val;
        @(negedge clk);
        acc_valid = 1'b0; data_acc = 1'b1; pg_wr_en = 1'b0;
        cmd_valid = 1'b0; instr_done = 1'b0;
    endtask

    task automatic acc(input logic [15:0] a, input logic d, input string tag);
        acc_valid = 1'b1; log_addr = a; data_acc = d;
        tick(tag);
    endtask

    task automatic cmd(input logic [1:0] k, input logic [9:0] v, input logic [1:0] l);
        cmd_valid = 1'b1; cmd_kind = k; cmd_val = v; cmd_len = l;
        instr_done = 1'b1;  // own retire pulse, not counted
    endtask

    task automatic retire_acc(input logic [15:0] a, input string tag);
        instr_done = 1'b1;
        acc(a, 1'b1, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) m_pg[i] = 10'(i);
        m_act = 1'b0; m_seg = 1'b0; m_cnt = 0; m_val = '0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (phys_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: phys_valid=%b expected 0", phys_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1 identity after reset
        acc(16'h9555, 1'b1, "R1");
        acc(16'hC001, 1'b1, "R1");
        acc(16'h0000, 1'b1, "R1");
        // R3: write with concurrent access uses old value, next uses new
        pg_wr_en = 1'b1; pg_wr_sel = 2'd2; pg_wr_val = 10'h001;
        acc(16'h9555, 1'b1, "R3");
        acc(16'h9555, 1'b1, "R3");   // expect 0x005555
        pg_wr_en = 1'b1; pg_wr_sel = 2'd0; pg_wr_val = 10'h3FF;
        tick("R3");
        acc(16'h0001, 1'b1, "R2");
        acc(16'h7FFF, 1'b1, "R2");
        // R4/R6: page override length 2
        cmd(2'b01, 10'h155, 2'd1);
        acc(16'hC123, 1'b1, "R6");   // command cycle: old state, normal
        acc(16'hC123, 1'b1, "R4");
        retire_acc(16'h0042, "R6");
        retire_acc(16'h4042, "R6");  // last covered retire cycle still overridden
        acc(16'h4042, 1'b1, "R6");   // closed
        // R5/R10: segment override length 1
        cmd(2'b00, 10'h0AB, 2'd0);
        tick("R5");
        acc(16'h1234, 1'b1, "R5");
        acc(16'h1234, 1'b0, "R10");
        retire_acc(16'hFFFF, "R5");
        acc(16'hFFFF, 1'b1, "R6");
        // R7: chaining, length 2 then reload with length 4
        cmd(2'b11, 10'h2AA, 2'd1);
        tick("R7");
        retire_acc(16'h8001, "R7");
        cmd(2'b10, 10'h0CD, 2'd3);
        acc(16'h8001, 1'b1, "R7");
        retire_acc(16'h8002, "R7");
        retire_acc(16'h8003, "R7");
        retire_acc(16'h8004, "R7");
        acc(16'h8005, 1'b1, "R7");   // one covered instruction left
        retire_acc(16'h8006, "R7");
        acc(16'h8007, 1'b1, "R7");   // closed
        // R8: trap inside a window
        cmd(2'b01, 10'h111, 2'd3);
        tick("R8");
        acc(16'h2222, 1'b1, "R8");
        trap_b = 1'b1;
        acc(16'h2222, 1'b1, "R8");
        trap_b = 1'b0;
        acc(16'h2222, 1'b1, "R8");
        // R9: command during trap ignored
        trap_b = 1'b1;
        cmd(2'b01, 10'h333, 2'd3);
        acc(16'h3333, 1'b1, "R9");
        trap_b = 1'b0;
        acc(16'h3333, 1'b1, "R9");
        acc(16'hB333, 1'b1, "R9");
        repeat (3) tick("R2");
        n_chk++;
        if (q_exp.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d outputs missing, expected 0", q_exp.size());
        end
        finish_run();
    end
endmodule